// File: doc/BRIEF.md
# Mode-Banked Register File

This block is a 32-bit general register file for a processor with several operating modes. A 5-bit mode input selects which of sixteen visible registers reach the ports. Some indices lead to storage that every mode shares. Other indices lead to private copies that belong only to the current mode. The fast-interrupt mode has private copies of indices 8 through 14. Every other exception mode has private copies of only the stack pointer (index 13) and the link register (index 14).

There are two combinational read ports and one write port that stores on the clock edge. Each port takes a 4-bit index, and the block resolves that index through the mode that is current in that cycle.

Index 15 is the program counter, which is kept outside the block. A read of index 15 returns the `pc_value` input. A write to index 15 stores nothing. Instead, it is reported one cycle later as a branch request that carries the written value.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `redirect_valid` is 0. Reset clears all physical registers to zero.
- R2: Indices 0 to 7 address a single physical set. A value written to one of them in any mode is read back unchanged in every other mode.
- R3: In mode code 5'b10001 (fast interrupt), indices 8 to 14 address seven private registers. Writes to them there are invisible from other modes, and writes from other modes are invisible there.
- R4: In mode codes 5'b10010 (interrupt), 5'b10011 (supervisor), 5'b10111 (abort) and 5'b11011 (undefined), indices 13 and 14 address two registers private to that mode. Indices 0 to 12 are shared with user mode.
- R5: Mode code 5'b11111 (system) addresses exactly the same registers as mode code 5'b10000 (user).
- R6: A read of index 15 on either port returns `pc_value` in the same cycle.
- R7: A write to index 15 changes no register. In the next cycle `redirect_valid` is 1 and `redirect_addr` equals the written data. In any cycle that does not follow such a write, `redirect_valid` is 0.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R9: Any mode code not listed in R3 to R5 addresses the user bank.
- R10: The two read ports resolve their indices independently and may address any two registers at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 5 | Current processor mode code |
| pc_value | input | 32 | Program counter value returned for index 15 |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| redirect_valid | output | 1 | One-cycle pulse after a write to index 15 |
| redirect_addr | output | 32 | Data of the most recent write to index 15 |

## Verification
The write-visibility property assumes two things in the cycle after a write: the mode is unchanged, and a read port points at the same index. It only draws a conclusion when both hold. The bench therefore changes the mode and the indices only at the falling edge, and it keeps `wr_en` low during reset so that no write falls into the reset window.

The redirect properties assume that `wr_idx` is meaningful only while `wr_en` is high. The random stimulus freely mixes mode codes, including unlisted ones, with writes to index 15. The write data is drawn from the full 32-bit range, so aliasing between banks would show up as a wrong value.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode,
  input  logic [DW-1:0] pc_value,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          redirect_valid,
  output logic [DW-1:0] redirect_addr
);

  localparam int NSHARED = 15;
  localparam int NFAST   = 7;
  localparam int NPAIR   = 2;
  localparam int NEXC    = 4;
  localparam int NPHYS   = NSHARED + NFAST + NPAIR * NEXC;
  localparam int PW      = $clog2(NPHYS);

  localparam logic [4:0] M_FAST  = 5'b10001;
  localparam logic [4:0] M_INTR  = 5'b10010;
  localparam logic [4:0] M_SUPV  = 5'b10011;
  localparam logic [4:0] M_ABRT  = 5'b10111;
  localparam logic [4:0] M_UNDEF = 5'b11011;

  logic [DW-1:0] bank [NPHYS];

  function automatic logic [PW-1:0] resolve(input logic [4:0] m, input logic [3:0] idx);
    logic [PW-1:0] base;
    logic          pair_mode;
    pair_mode = 1'b1;
    case (m)
      M_INTR:  base = PW'(NSHARED + NFAST);
      M_SUPV:  base = PW'(NSHARED + NFAST + NPAIR);
      M_ABRT:  base = PW'(NSHARED + NFAST + 2 * NPAIR);
      M_UNDEF: base = PW'(NSHARED + NFAST + 3 * NPAIR);
      default: begin base = '0; pair_mode = 1'b0; end
    endcase
    if (m == M_FAST && idx >= 4'd8)
      resolve = PW'(NSHARED) + PW'(idx - 4'd8);
    else if (pair_mode && idx >= 4'd13)
      resolve = base + PW'(idx - 4'd13);
    else
      resolve = PW'(idx);
  endfunction

  logic          wr_pc;
  logic [PW-1:0] wr_slot;

  assign wr_pc   = wr_en && (wr_idx == 4'hF);
  assign wr_slot = resolve(mode, wr_idx);

  assign rd_a_data = (rd_a_idx == 4'hF) ? pc_value : bank[resolve(mode, rd_a_idx)];
  assign rd_b_data = (rd_b_idx == 4'hF) ? pc_value : bank[resolve(mode, rd_b_idx)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) bank[i] <= '0;
    end else if (wr_en && !wr_pc) begin
      bank[wr_slot] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
    end else begin
      redirect_valid <= wr_pc;
      if (wr_pc) redirect_addr <= wr_data;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !redirect_valid);

  p_pc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 4'hF) |-> (rd_b_data == pc_value));

  p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'hF) |=> (redirect_valid && redirect_addr == $past(wr_data)));

  p_redirect_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == 4'hF) |=> !redirect_valid);

  p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) != 4'hF &&
     mode == $past(mode) && rd_a_idx == $past(wr_idx))
    |-> (rd_a_data == $past(wr_data)));

endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'b10000;
  logic [31:0] pc_value = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, redirect_addr;
  logic        wr_en = 1'b0, redirect_valid;

  int tests = 0, fails = 0;
  logic [31:0] model [30];

  always #10 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pc_value(pc_value),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr));

  function automatic int group_of(input logic [4:0] m);
    if (m == 5'b10001) return 1;
    if (m == 5'b10010) return 2;
    if (m == 5'b10011) return 3;
    if (m == 5'b10111) return 4;
    if (m == 5'b11011) return 5;
    return 0;
  endfunction

  function automatic int slot_of(input logic [4:0] m, input logic [3:0] idx);
    int g = group_of(m);
    if (g == 1 && idx >= 8) return 15 + int'(idx) - 8;
    if (g >= 2 && idx >= 13) return 22 + (g - 2) * 2 + int'(idx) - 13;
    return int'(idx);
  endfunction

  function automatic logic [31:0] expect_rd(input logic [4:0] m, input logic [3:0] idx);
    if (idx == 4'hF) return pc_value;
    return model[slot_of(m, idx)];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb,
                      input logic we, input logic [3:0] wi, input logic [31:0] wd,
                      input string req);
    logic [31:0] ea, eb;
    @(negedge clk);
    mode = m; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd; pc_value = $urandom;
    #1;
    ea = expect_rd(m, ra);
    eb = expect_rd(m, rb);
    chk(rd_a_data === ea, req, rd_a_data, ea);
    chk(rd_b_data === eb, req, rd_b_data, eb);
    @(posedge clk);
    #1;
    if (we && wi != 4'hF) model[slot_of(m, wi)] = wd;
    chk(redirect_valid === (we && wi == 4'hF), "R7", {31'b0, redirect_valid}, {31'b0, we && wi == 4'hF});
    if (we && wi == 4'hF) chk(redirect_addr === wd, "R7", redirect_addr, wd);
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] wi, input logic [31:0] wd, input string req);
    step(m, 4'd0, 4'd15, 1'b1, wi, wd, req);
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb, input string req);
    step(m, ra, rb, 1'b0, 4'd0, 32'd0, req);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [4:0] modes [8];
    void'($urandom(32'd20240917));
    modes[0] = 5'b10000; modes[1] = 5'b10001; modes[2] = 5'b10010; modes[3] = 5'b10011;
    modes[4] = 5'b10111; modes[5] = 5'b11011; modes[6] = 5'b11111; modes[7] = 5'b00000;
    for (int i = 0; i < 30; i++) model[i] = '0;

    repeat (3) @(posedge clk);
    #1;
    chk(redirect_valid === 1'b0, "R1", {31'b0, redirect_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(redirect_valid === 1'b0, "R1", {31'b0, redirect_valid}, 32'd0);

    for (int m = 0; m < 7; m++)
      for (int k = 0; k < 15; k += 2) rd(modes[m], 4'(k), 4'(k + 1), "R1");

    wr(5'b10001, 4'd3, 32'hA5A5_0003, "R2");
    rd(5'b10010, 4'd3, 4'd3, "R2");
    rd(5'b11011, 4'd3, 4'd7, "R2");

    wr(5'b10001, 4'd8, 32'hF1F1_0008, "R3");
    wr(5'b10000, 4'd8, 32'h0505_0008, "R3");
    rd(5'b10001, 4'd8, 4'd14, "R3");
    rd(5'b10011, 4'd8, 4'd8, "R3");

    wr(5'b10011, 4'd13, 32'h5C5C_000D, "R4");
    wr(5'b10111, 4'd13, 32'hAB0A_000D, "R4");
    wr(5'b10010, 4'd12, 32'h1212_000C, "R4");
    rd(5'b10011, 4'd13, 4'd12, "R4");
    rd(5'b10000, 4'd13, 4'd12, "R4");
    rd(5'b10111, 4'd13, 4'd14, "R4");

    wr(5'b11111, 4'd14, 32'h5151_000E, "R5");
    rd(5'b10000, 4'd14, 4'd13, "R5");

    rd(5'b10000, 4'd15, 4'd15, "R6");
    wr(5'b10010, 4'd15, 32'hDEAD_BEEF, "R7");
    rd(5'b10000, 4'd15, 4'd0, "R7");

    wr(5'b10000, 4'd5, 32'h0000_0055, "R8");
    step(5'b10000, 4'd5, 4'd5, 1'b1, 4'd5, 32'h0000_0066, "R8");
    rd(5'b10000, 4'd5, 4'd5, "R8");

    wr(5'b00110, 4'd13, 32'h0909_000D, "R9");
    rd(5'b10000, 4'd13, 4'd13, "R9");
    rd(5'b01010, 4'd13, 4'd8, "R9");

    for (int n = 0; n < 4000; n++) begin
      logic [4:0] m;
      m = modes[$urandom_range(0, 7)];
      if (m == 5'b00000) m = 5'($urandom);
      step(m, 4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom, "R10");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule